// File: doc/BRIEF.md
# Two-Digit BCD Year Counter

This block holds the year field of a real-time clock calendar as two packed BCD digits: the tens digit in the upper nibble and the units digit in the lower nibble. Each single-cycle carry pulse from the month stage advances the year by one while the clock is running. Past 99 it rolls over to 00. A combinational flag tells the day-of-month logic whether the current year is a leap year, so that February can be given its 29th day.

Software loads a starting year through a plain write strobe with data. The block accepts that write only while the run control is low, which means counting is stopped. The stored value is always visible on the read port, straight from the register. The storage element has no reset value. A power-on reset, a manual reset or a standby period leaves the year as it was, and counting carries on through them.

Top module: `bcd_year_counter`

## Requirements
- R1: `year_o` always shows the stored register value. It reflects an accepted update one clock edge after the update is applied.
- R2: When `run_i`=1 and `carry_i`=1 at a clock edge, the stored year increases by exactly one in decimal, for example 47 to 48.
- R3: When the units digit (bits 3:0) is 9, an increment sets it to 0 and raises the tens digit (bits 7:4) by one, for example 49 to 50.
- R4: An increment from 99 (8'h99) gives 00 (8'h00).
- R5: A carry pulse while `run_i`=0 leaves the stored year unchanged.
- R6: When `wr_en_i`=1 and `run_i`=0 at a clock edge, `wr_data_i` becomes the stored year. In that cycle a write takes precedence over any increment.
- R7: A write strobe while `run_i`=1 is ignored and the year keeps its value.
- R8: `leap_o`=1 exactly when the stored year value modulo 4 is 0, with 00 counted as a leap year. For an even tens digit this holds when units is 0, 4 or 8. For an odd tens digit it holds when units is 2 or 6.
- R9: `rst_i` does not clear or alter the year. Increments requested while `rst_i`=1 still take effect.
- R10: With no write strobe and no carry pulse, the year holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high system reset; does not affect the year |
| run_i | input | 1 | 1 = counting enabled, 0 = halted and writable |
| carry_i | input | 1 | Year-carry pulse from the month stage |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Packed BCD year to load |
| year_o | output | 8 | Current packed BCD year |
| leap_o | output | 1 | Current year is a leap year |

## Verification
The increment path is driven from a middle value (47), through a units-digit rollover (49 to 50) and through the full wrap from 99 to 00. These separate a plain units increment from the carry into the tens digit and from the two-digit wrap. Write strobes and carry pulses are applied with the run control high and low, which shows whether the gating follows that control. A long sweep from 00 through all one hundred years compares the leap flag against modulo-4 arithmetic on every value, which separates the odd-tens rule from the even-tens rule. Reset is pulsed both while idle and while counting, which exposes any hidden clear.

// File: rtl/year_pkg.sv
package year_pkg;

    localparam int unsigned DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef struct packed {
        bcd_digit_t tens;
        bcd_digit_t units;
    } year_pair_t;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } year_upd_e;

    function automatic logic digit_is_nine(input bcd_digit_t d);
        return d == bcd_digit_t'(9);
    endfunction

    function automatic year_upd_e pick_update(input logic run,
                                              input logic carry,
                                              input logic wr_en);
        if (wr_en && !run)
            return UPD_LOAD;
        else if (run && carry)
            return UPD_STEP;
        else
            return UPD_HOLD;
    endfunction

endpackage

// File: rtl/yr_digit_chain.sv
module yr_digit_chain
    import year_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 2,
    localparam int unsigned DW = NUM_DIGITS * DIGIT_W
) (
    input  logic [DW-1:0] cur_i,
    output logic [DW-1:0] next_o
);

    logic [NUM_DIGITS:0] ripple;

    assign ripple[0] = 1'b1;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        bcd_digit_t d;
        logic       wrap;

        assign d    = cur_i[g*DIGIT_W +: DIGIT_W];
        assign wrap = ripple[g] && digit_is_nine(d);

        assign next_o[g*DIGIT_W +: DIGIT_W] =
            wrap ? '0 : (d + bcd_digit_t'(ripple[g]));
        assign ripple[g+1] = wrap;
    end

endmodule

// File: rtl/yr_leap_detect.sv
module yr_leap_detect
    import year_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 2,
    localparam int unsigned DW = NUM_DIGITS * DIGIT_W
) (
    input  logic [DW-1:0] year_i,
    output logic          leap_o
);

    bcd_digit_t units;
    bcd_digit_t tens;

    assign units = year_i[DIGIT_W-1:0];

    if (NUM_DIGITS > 1) begin : g_tens
        assign tens = year_i[2*DIGIT_W-1:DIGIT_W];
    end else begin : g_no_tens
        assign tens = '0;
    end

    always_comb begin
        if (tens[0])
            leap_o = (units == 4'd2) || (units == 4'd6);
        else
            leap_o = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
    end

endmodule

// File: rtl/yr_store.sv
module yr_store
    import year_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 2,
    localparam int unsigned DW = NUM_DIGITS * DIGIT_W
) (
    input  logic          clk_i,
    input  year_upd_e     upd_i,
    input  logic [DW-1:0] load_val_i,
    input  logic [DW-1:0] step_val_i,
    output logic [DW-1:0] q_o
);

    logic [DW-1:0] q;

    always_ff @(posedge clk_i) begin
        unique case (upd_i)
            UPD_LOAD: q <= load_val_i;
            UPD_STEP: q <= step_val_i;
            default:  q <= q;
        endcase
    end

    assign q_o = q;

endmodule

// File: rtl/bcd_year_counter.sv
module bcd_year_counter
    import year_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 2,
    localparam int unsigned DW = NUM_DIGITS * DIGIT_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic          carry_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] year_o,
    output logic          leap_o
);

    logic          rst_held_unused;
    year_upd_e     upd;
    logic [DW-1:0] cur_year;
    logic [DW-1:0] next_year;

    assign rst_held_unused = rst_i;
    assign upd = pick_update(run_i, carry_i, wr_en_i);

    yr_digit_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
        .cur_i  (cur_year),
        .next_o (next_year)
    );

    yr_store #(.NUM_DIGITS(NUM_DIGITS)) u_store (
        .clk_i      (clk_i),
        .upd_i      (upd),
        .load_val_i (wr_data_i),
        .step_val_i (next_year),
        .q_o        (cur_year)
    );

    yr_leap_detect #(.NUM_DIGITS(NUM_DIGITS)) u_leap (
        .year_i (cur_year),
        .leap_o (leap_o)
    );

    assign year_o = cur_year;

endmodule

// File: rtl/yr_counter_chk.sv
module yr_counter_chk #(
    parameter int unsigned NUM_DIGITS = 2,
    localparam int unsigned DW = NUM_DIGITS * 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          run_i,
    input logic          carry_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wr_data_i,
    input logic [DW-1:0] year_o,
    input logic          leap_o
);

    localparam int MODULUS = 10 ** NUM_DIGITS;

    function automatic int as_int(input logic [DW-1:0] v);
        int acc = 0;
        for (int k = NUM_DIGITS - 1; k >= 0; k--)
            acc = acc * 10 + int'(v[k*4 +: 4]);
        return acc;
    endfunction

    function automatic logic is_bcd(input logic [DW-1:0] v);
        logic ok = 1'b1;
        for (int k = 0; k < NUM_DIGITS; k++)
            if (v[k*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    logic loaded;
    always_ff @(posedge clk_i) begin
        if (rst_i)
            loaded <= 1'b0;
        else if (wr_en_i && !run_i)
            loaded <= 1'b1;
    end

    // R6
    load_takes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !run_i) |=> (year_o == $past(wr_data_i)));

    // R5 R7 R10
    hold_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (loaded && !(wr_en_i && !run_i) && !(run_i && carry_i)) |=> $stable(year_o));

    // R2 R3 R4
    step_by_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (loaded && run_i && carry_i && is_bcd(year_o))
        |=> (as_int(year_o) == (as_int($past(year_o)) + 1) % MODULUS));

    // R8
    leap_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (loaded && is_bcd(year_o)) |-> (leap_o == ((as_int(year_o) % 4) == 0)));

endmodule

bind bcd_year_counter yr_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_yr_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_i     (run_i),
    .carry_i   (carry_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .year_o    (year_o),
    .leap_o    (leap_o)
);

// File: tb/test_bcd_year_counter.sv
`timescale 1ns/1ps
module test_bcd_year_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       carry = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] year;
    logic       leap;

    int checks = 0;
    int errors = 0;
    int model = 0;

    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    bcd_year_counter i_bcd_year_counter (
        .clk_i     (clk),
        .rst_i     (rst),
        .run_i     (run),
        .carry_i   (carry),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .year_o    (year),
        .leap_o    (leap)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Driver: apply one cycle of stimulus, then queue the expected year.
    task automatic drive(input logic r, input logic c, input logic w,
                         input logic [7:0] d, input logic rs, input string tag);
        @(negedge clk);
        run = r; carry = c; wr_en = w; wr_data = d; rst = rs;
        @(posedge clk);
        if (w && !r)
            model = int'(d[7:4]) * 10 + int'(d[3:0]);
        else if (r && c)
            model = (model + 1) % 100;
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare value and leap flag away from the clock edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (year !== to_bcd(e)) begin
                errors++;
                $display("FAIL %s year actual=%h expected=%h", t, year, to_bcd(e));
            end
            checks++;
            if (leap !== ((e % 4) == 0)) begin
                errors++;
                $display("FAIL R8 leap at %h actual=%b expected=%b", to_bcd(e), leap, (e % 4) == 0);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                drive(0, 0, 1, 8'h47, 0, "R6 R1 load 47");
                drive(0, 1, 0, 8'h00, 0, "R5 carry halted");
                drive(0, 0, 0, 8'h00, 0, "R10 idle");
                drive(1, 1, 0, 8'h00, 0, "R2 step 48");
                drive(1, 1, 0, 8'h00, 0, "R2 step 49");
                drive(1, 1, 0, 8'h00, 0, "R3 units wrap 50");
                drive(1, 0, 1, 8'h12, 0, "R7 write while running");
                drive(1, 1, 1, 8'h33, 0, "R7 write with carry running");
                drive(0, 1, 1, 8'h98, 0, "R6 write wins over carry");
                drive(1, 1, 0, 8'h00, 0, "R2 step 99");
                drive(1, 1, 0, 8'h00, 0, "R4 wrap 00");
                drive(0, 0, 0, 8'h00, 1, "R9 reset idle");
                drive(1, 1, 0, 8'h00, 1, "R9 reset while counting");
                drive(0, 0, 0, 8'h00, 0, "R9 after reset");
                drive(0, 0, 1, 8'h00, 0, "R6 load 00");
                for (int i = 0; i < 100; i++)
                    drive(1, 1, 0, 8'h00, 0, "R8 R2 sweep");
                @(negedge clk);
                run = 0; carry = 0;
                repeat (2) @(negedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule